// File: doc/BRIEF.md
# Vectored Primary Interrupt Controller

This controller collects a parameterised number of level-sensitive interrupt inputs (64 by default) and presents them to a processor as two request lines. One line is a normal interrupt request (IRQ) and the other is a fast interrupt request (FIQ). Each source owns one 32-bit configuration word on a simple memory-mapped bus. Two route bits in that word connect the source to IRQ, to FIQ, to both, or to neither. A source with neither route bit set is disabled.

Software services an interrupt by reading a select word. The select word carries a pending flag and the number of the lowest-numbered active source that is routed to IRQ. Reading it changes nothing. A source stops being pending only when its input falls or when software clears its route bits. Both request outputs are registered, and bus reads return data one clock after the request.

Top module: `prim_irq_ctrl`

## Requirements
- R1: After reset every route bit is 0, `irq_o` and `fiq_o` are low, and every register reads 0.
- R2: The configuration word of source n sits at byte address 4*n. It stores only bit 5 (IRQ route) and bit 6 (FIQ route), and every other bit reads 0.
- R3: `irq_o` is high in the cycle after an edge where at least one input is high with its IRQ route bit set, and low otherwise.
- R4: `fiq_o` follows the same rule as `irq_o`, using the FIQ route bit.
- R5: A source with both route bits at 0 affects neither output, even while its input is high. Clearing the route bits of an active source drops its request.
- R6: The select word sits at byte address 0x104. Its bit 6 is 1 exactly when some input is high with its IRQ route bit set; sources routed only to FIQ do not set it.
- R7: When several IRQ-routed sources are active, bits 5:0 of the select word hold the lowest source number.
- R8: With nothing pending, the select word reads as 0 in all bits.
- R9: Pending state is level-based. It persists while the input stays high and follows the input when it falls. Repeated select reads return the same value.
- R10: Writes to the select address or to any address with no register change no state. Reads from unmapped addresses return 0.
- R11: `bus_rdata_o` is loaded one clock after a read request and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt inputs |
| bus_sel_i | input | 1 | Bus access request, one cycle per access |
| bus_wr_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The bench drives three kinds of input pattern.

- **Single active sources.** These separate the two route bits from each other and from a disabled source.
- **Overlapping sources.** Sources 2, 5 and 40 overlap, and later sources 0 and 63 overlap. These patterns separate the lowest-number priority from any other order, and they separate a number-0 winner from an empty select word.
- **Falling inputs and cleared routes.** Inputs fall while others stay high, and route bits are cleared under an active input. These patterns show that pending state follows levels rather than latched events.

Stray writes to the select word and to unmapped addresses, followed by read-back, separate decode errors from correct ignoring.

// File: rtl/prim_irq_pkg.sv
package prim_irq_pkg;
   localparam int ROUTE_IRQ_BIT = 5;
   localparam int ROUTE_FIQ_BIT = 6;
   localparam int SEL_PEND_BIT  = 6;
   localparam int SEL_NUM_W     = 6;
   localparam int DATA_W        = 32;

   typedef struct packed {
      logic fiq;
      logic irq;
   } route_t;

   function automatic logic [DATA_W-1:0] route_to_word(route_t r);
      logic [DATA_W-1:0] w;
      w = '0;
      w[ROUTE_IRQ_BIT] = r.irq;
      w[ROUTE_FIQ_BIT] = r.fiq;
      return w;
   endfunction
endpackage

// File: rtl/pic_cfg_bank.sv
module pic_cfg_bank
   import prim_irq_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int WORD_W  = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [WORD_W-1:0]  word,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_SRC-1:0] route_irq,
   output logic [NUM_SRC-1:0] route_fiq,
   output logic [DATA_W-1:0]  rd_word
);
   route_t cfg_q [NUM_SRC];

   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[n] <= '0;
         end else if (wr_en && (word == WORD_W'(n))) begin
            cfg_q[n].irq <= wdata[ROUTE_IRQ_BIT];
            cfg_q[n].fiq <= wdata[ROUTE_FIQ_BIT];
         end
      end
      assign route_irq[n] = cfg_q[n].irq;
      assign route_fiq[n] = cfg_q[n].fiq;
   end

   always_comb begin
      rd_word = '0;
      for (int n = 0; n < NUM_SRC; n++) begin
         if (word == WORD_W'(n)) rd_word = route_to_word(cfg_q[n]);
      end
   end
endmodule

// File: rtl/pic_first_pick.sv
module pic_first_pick #(
   parameter int N         = 64,
   parameter int IDX_W     = 6,
   parameter bit PICK_TREE = 1'b1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   if (N < 2) begin : g_bad_n
      $error("pic_first_pick: N must be at least 2");
   end
   if ((1 << IDX_W) < N) begin : g_bad_idx
      $error("pic_first_pick: IDX_W too narrow for N");
   end

   if (PICK_TREE) begin : g_tree
      localparam int LVL = $clog2(N);
      localparam int P   = 1 << LVL;
      logic [P-1:0]     v  [LVL+1];
      logic [IDX_W-1:0] ix [LVL+1][P];

      for (genvar i = 0; i < P; i++) begin : g_leaf
         if (i < N) begin : g_real
            assign v[0][i] = req[i];
         end else begin : g_pad
            assign v[0][i] = 1'b0;
         end
         assign ix[0][i] = IDX_W'(i);
      end

      for (genvar l = 0; l < LVL; l++) begin : g_lvl
         for (genvar j = 0; j < P; j++) begin : g_node
            if (j < (P >> (l + 1))) begin : g_live
               assign v[l+1][j]  = v[l][2*j] | v[l][2*j+1];
               assign ix[l+1][j] = v[l][2*j] ? ix[l][2*j] : ix[l][2*j+1];
            end else begin : g_dead
               assign v[l+1][j]  = 1'b0;
               assign ix[l+1][j] = '0;
            end
         end
      end

      assign any = v[LVL][0];
      assign idx = v[LVL][0] ? ix[LVL][0] : '0;
   end else begin : g_linear
      always_comb begin
         any = 1'b0;
         idx = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
               any = 1'b1;
               idx = IDX_W'(i);
            end
         end
      end
   end
endmodule

// File: rtl/prim_irq_ctrl.sv
module prim_irq_ctrl
   import prim_irq_pkg::*;
#(
   parameter int NUM_SRC    = 64,
   parameter int ADDR_W     = 12,
   parameter int SEL_OFFSET = 'h104,
   parameter bit PICK_TREE  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  src_i,
   input  logic                bus_sel_i,
   input  logic                bus_wr_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   output logic [DATA_W-1:0]   bus_rdata_o,
   output logic                irq_o,
   output logic                fiq_o
);
   localparam int WORD_W   = ADDR_W - 2;
   localparam int SEL_WORD = SEL_OFFSET / 4;

   if (NUM_SRC > (1 << SEL_NUM_W)) begin : g_bad_src
      $error("prim_irq_ctrl: NUM_SRC exceeds select number field");
   end
   if (SEL_WORD < NUM_SRC || SEL_WORD >= (1 << WORD_W)) begin : g_bad_sel
      $error("prim_irq_ctrl: select word overlaps config space or lies outside address range");
   end
   if (SEL_PEND_BIT < SEL_NUM_W) begin : g_bad_pend
      $error("prim_irq_ctrl: pending flag overlaps number field");
   end

   logic [WORD_W-1:0]    word;
   logic                 wr_en, rd_en, sel_hit;
   logic [NUM_SRC-1:0]   route_irq, route_fiq;
   logic [NUM_SRC-1:0]   act_irq, act_fiq;
   logic [DATA_W-1:0]    cfg_rd, sel_rd, rd_next;
   logic                 pick_any;
   logic [SEL_NUM_W-1:0] pick_idx;

   assign word    = bus_addr_i[ADDR_W-1:2];
   assign wr_en   = bus_sel_i & bus_wr_i;
   assign rd_en   = bus_sel_i & ~bus_wr_i;
   assign sel_hit = (word == WORD_W'(SEL_WORD));

   pic_cfg_bank #(
      .NUM_SRC(NUM_SRC),
      .WORD_W (WORD_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .word     (word),
      .wdata    (bus_wdata_i),
      .route_irq(route_irq),
      .route_fiq(route_fiq),
      .rd_word  (cfg_rd)
   );

   assign act_irq = src_i & route_irq;
   assign act_fiq = src_i & route_fiq;

   pic_first_pick #(
      .N        (NUM_SRC),
      .IDX_W    (SEL_NUM_W),
      .PICK_TREE(PICK_TREE)
   ) u_pick (
      .req(act_irq),
      .any(pick_any),
      .idx(pick_idx)
   );

   always_comb begin
      sel_rd = '0;
      if (pick_any) begin
         sel_rd[SEL_PEND_BIT]    = 1'b1;
         sel_rd[SEL_NUM_W-1:0]   = pick_idx;
      end
   end

   assign rd_next = sel_hit ? sel_rd : cfg_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata_o <= '0;
         irq_o       <= 1'b0;
         fiq_o       <= 1'b0;
      end else begin
         if (rd_en) bus_rdata_o <= rd_next;
         irq_o <= |act_irq;
         fiq_o <= |act_fiq;
      end
   end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
   parameter int NUM_SRC    = 64,
   parameter int ADDR_W     = 12,
   parameter int SEL_OFFSET = 'h104
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_i,
   input logic [NUM_SRC-1:0] route_irq,
   input logic [NUM_SRC-1:0] route_fiq,
   input logic               bus_sel_i,
   input logic               bus_wr_i,
   input logic [ADDR_W-1:0]  bus_addr_i,
   input logic [31:0]        bus_rdata_o,
   input logic               irq_o,
   input logic               fiq_o
);
   logic               rd_q, rd_sel_q;
   logic [NUM_SRC-1:0] pend_prev;
   logic [NUM_SRC-1:0] low_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q      <= 1'b0;
         rd_sel_q  <= 1'b0;
         pend_prev <= '0;
      end else begin
         rd_q      <= bus_sel_i & ~bus_wr_i;
         rd_sel_q  <= bus_sel_i & ~bus_wr_i & (bus_addr_i == ADDR_W'(SEL_OFFSET));
         pend_prev <= src_i & route_irq;
      end
   end

   assign low_mask = ({{(NUM_SRC-1){1'b0}}, 1'b1} << bus_rdata_o[5:0]) - 1'b1;

   assert_reset_quiet_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!irq_o && !fiq_o && bus_rdata_o == 32'h0));

   assert_irq_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(src_i & route_irq)) |=> irq_o);
   assert_irq_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(src_i & route_irq)) |=> !irq_o);

   assert_fiq_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(src_i & route_fiq)) |=> fiq_o);
   assert_fiq_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(src_i & route_fiq)) |=> !fiq_o);

   assert_sel_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel_q && bus_rdata_o[6]) |->
         (pend_prev[bus_rdata_o[5:0]] && ((pend_prev & low_mask) == '0)));

   assert_sel_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel_q && !bus_rdata_o[6]) |-> (bus_rdata_o == 32'h0 && pend_prev == '0));

   assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_q |-> $stable(bus_rdata_o));
endmodule

bind prim_irq_ctrl pic_checker #(
   .NUM_SRC   (NUM_SRC),
   .ADDR_W    (ADDR_W),
   .SEL_OFFSET(SEL_OFFSET)
) u_pic_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .src_i      (src_i),
   .route_irq  (route_irq),
   .route_fiq  (route_fiq),
   .bus_sel_i  (bus_sel_i),
   .bus_wr_i   (bus_wr_i),
   .bus_addr_i (bus_addr_i),
   .bus_rdata_o(bus_rdata_o),
   .irq_o      (irq_o),
   .fiq_o      (fiq_o)
);

// File: tb/test_prim_irq_ctrl.sv
`timescale 1ns/1ps
module test_prim_irq_ctrl;
   localparam int NSRC = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src = '0;
   logic            sel = 1'b0, wr = 1'b0;
   logic [11:0]     addr = '0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic            irq, fiq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   prim_irq_ctrl i_prim_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .src_i(src),
      .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .irq_o(irq), .fiq_o(fiq)
   );

   // behavioural reference model
   bit          m_irq [NSRC];
   bit          m_fiq [NSRC];
   logic [31:0] e_rdata = '0;
   bit          e_irq = 0, e_fiq = 0;

   function automatic logic [31:0] model_read(logic [11:0] a);
      int w = int'(a >> 2);
      if (w < NSRC) return {25'd0, m_fiq[w], m_irq[w], 5'd0};
      if (a == 12'h104) begin
         for (int k = 0; k < NSRC; k++)
            if (src[k] && m_irq[k]) return 32'h40 | k;
         return 32'h0;
      end
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NSRC; k++) begin m_irq[k] = 0; m_fiq[k] = 0; end
         e_rdata = 0; e_irq = 0; e_fiq = 0;
      end else begin
         e_irq = 0; e_fiq = 0;
         for (int k = 0; k < NSRC; k++) begin
            if (src[k] && m_irq[k]) e_irq = 1;
            if (src[k] && m_fiq[k]) e_fiq = 1;
         end
         if (sel && !wr) e_rdata = model_read(addr);
         if (sel && wr && int'(addr >> 2) < NSRC) begin
            m_irq[addr >> 2] = wdata[5];
            m_fiq[addr >> 2] = wdata[6];
         end
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R3 irq_o vs model", {31'd0, irq}, {31'd0, e_irq});
         check("R4 fiq_o vs model", {31'd0, fiq}, {31'd0, e_fiq});
         check("R11 rdata vs model", rdata, e_rdata);
      end
   end

   task automatic bus_write(logic [11:0] a, logic [31:0] d);
      @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
      @(negedge clk); sel = 0; wr = 0;
   endtask

   task automatic bus_read(logic [11:0] a, output logic [31:0] d);
      @(negedge clk); sel = 1; wr = 0; addr = a;
      @(negedge clk); sel = 0; d = rdata;
   endtask

   task automatic settle();
      @(negedge clk); @(negedge clk);
   endtask

   initial begin
      logic [31:0] d, held;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 irq_o after reset", {31'd0, irq}, 0);
      check("R1 fiq_o after reset", {31'd0, fiq}, 0);
      bus_read(12'h104, d); check("R1 R8 select after reset", d, 0);
      bus_read(12'd40, d);  check("R1 cfg10 after reset", d, 0);

      bus_write(12'd20, 32'hFFFF_FFFF);
      bus_read(12'd20, d);  check("R2 cfg5 keeps only route bits", d, 32'h60);
      bus_write(12'd20, 32'h20);
      bus_read(12'd20, d);  check("R2 cfg5 irq route", d, 32'h20);

      src[5] = 1; settle();
      check("R3 irq_o from source 5", {31'd0, irq}, 1);
      check("R4 fiq_o stays low", {31'd0, fiq}, 0);
      bus_read(12'h104, d); check("R6 select source 5", d, 32'h45);
      bus_read(12'h104, d); check("R9 repeat select read", d, 32'h45);

      bus_write(12'd8, 32'h20); bus_write(12'd160, 32'h60);
      src[2] = 1; src[40] = 1; settle();
      bus_read(12'h104, d); check("R7 lowest of 2,5,40", d, 32'h42);
      src[2] = 0; settle();
      bus_read(12'h104, d); check("R9 falls back to 5", d, 32'h45);

      bus_write(12'd252, 32'h40); src[63] = 1; settle();
      check("R4 fiq_o from source 63", {31'd0, fiq}, 1);

      src[10] = 1; src[5] = 0; src[40] = 0; settle();
      check("R5 disabled source 10 gives no irq", {31'd0, irq}, 0);
      bus_read(12'h104, d); check("R6 R8 fiq-only leaves select empty", d, 0);

      bus_write(12'h104, 32'h7F); bus_write(12'h200, 32'hFFFF_FFFF);
      bus_read(12'd0, d);   check("R10 stray writes leave cfg0", d, 0);
      bus_read(12'h200, d); check("R10 unmapped read is zero", d, 0);

      src[40] = 1; settle();
      check("R3 irq from source 40", {31'd0, irq}, 1);
      bus_write(12'd160, 32'h0); settle();
      check("R5 cleared routes drop irq", {31'd0, irq}, 0);
      check("R5 cleared routes drop fiq from 40 but 63 holds", {31'd0, fiq}, 1);

      bus_write(12'd0, 32'h20); bus_write(12'd252, 32'h60);
      src[0] = 1; settle();
      bus_read(12'h104, d); check("R7 source 0 wins over 63", d, 32'h40);
      held = d;
      repeat (3) @(negedge clk);
      check("R11 rdata held without reads", rdata, held);

      src = '0; settle();
      check("R9 irq follows falling inputs", {31'd0, irq}, 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule